// File: doc/BRIEF.md
# Flash Read-Protection and Verify Gate

This block guards the path between a program-flash read port and the agents that ask for data from it. Every request names a kind and an address. The block carries the data that the memory side presents on `mem_rdata` to the requester, or it refuses the request. Refusal depends on a protection level, and that level is decoded from three lock bits that can only move toward tighter protection until a mass erase. Verify reads can be scrambled against a 64-byte key store. Once any key byte differs from FFh, each verify byte is XNORed with the key byte chosen by the low six address bits.

The block also answers information reads. These return an option byte that carries a power-up watchdog disable flag, and three fixed identification bytes. It latches the external-access pin while the CPU is held in reset. Lock bits, key bytes and the option flag are modelled as registers with program and mass-erase commands. Every request gets one registered response one clock later.

Top module: `flash_guard`

## Requirements
- R1: `lvl_o` reports the protection level decoded from lock bits {LB3,LB2,LB1}, with the highest level taking priority. LB3=0 gives 3 (level 4). Otherwise LB2=0 gives 2 (level 3). Otherwise LB1=0 gives 1 (level 2). All ones gives 0 (level 1). Reset leaves all lock bits at 1.
- R2: A lock-program request (kind 4) sets the lock bits to old AND `req_wdata[2:0]`, where bit 0 is LB1, bit 1 is LB2 and bit 2 is LB3. A bit written as 1 never raises a cleared lock bit. The request is accepted at every level.
- R3: A mass erase (kind 7) returns the lock bits to 111 and every key byte to FFh. It pulses `prog_erase_o` for one cycle together with its response, and it leaves the option flag unchanged.
- R4: A code read issued from external code (kind 0) returns `mem_rdata` at level value 0. At level value 1 or higher it returns FFh with `viol_o`=1.
- R5: A data read of internal SRAM issued from external code (kind 1) is refused when the level value is 2 or higher. A refused read returns FFh with `viol_o`=1.
- R6: A verify read (kind 2) is refused when the level value is 2 or higher. Otherwise it returns `mem_rdata` XNOR key[addr[5:0]] when some key byte is not FFh, and plain `mem_rdata` when all key bytes are FFh.
- R7: An external instruction fetch (kind 3) passes `mem_rdata` unless the level value is 3. At level value 3 it returns FFh with `viol_o`=1.
- R8: A key-byte program (kind 5, byte `req_wdata` written at addr[5:0]) or an option program (kind 6, flag = `req_wdata[3]`) is accepted only at level value 0. At a higher level the response has `rsp_err_o`=1 and storage is unchanged.
- R9: An information read (kind 8) at address FCh returns a byte with bit 3 equal to the watchdog disable flag and all other bits 1. The flag resets to 1.
- R10: An information read returns DAh at 30h, the `DEV_ID` parameter (default 43h) at 31h, 01h at 60h and FFh at any other address.
- R11: At level value 0, `ea_o` follows `ea_pin_i`. At a higher level it holds the value `ea_pin_i` had during the last cycle in which `cpu_rst_i` was high.
- R12: A request sampled at a rising edge produces `rsp_valid_o`=1 with its data, `viol_o` and `rsp_err_o` in the cycle after. With no request, `rsp_valid_o`, `viol_o` and `rsp_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| cpu_rst_i | input | 1 | CPU reset, during which the external-access pin is sampled |
| ea_pin_i | input | 1 | External-access pin level |
| req_valid_i | input | 1 | Request strobe |
| req_kind_i | input | 4 | Request kind code (see R2 to R10) |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | 8 | Program data |
| mem_rdata_i | input | 8 | Data offered by the memory side for this request |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_data_o | output | 8 | Response data |
| viol_o | output | 1 | Refused-read pulse |
| rsp_err_o | output | 1 | Refused program or unknown kind |
| prog_erase_o | output | 1 | Program-array erase pulse |
| lvl_o | output | 2 | Decoded protection level |
| ea_o | output | 1 | Effective external-access level |

## Verification
Each request is sampled at one rising edge, and its response, violation flag, error flag and erase pulse appear on the outputs right after the next edge. Every scenario task therefore drives at a falling edge and reads the results one nanosecond after the following rising edge. A state change made by a request, such as the lock bits, the level or a key byte, is checked through `lvl_o` or through the response of a later request. `lvl_o` is combinational from the lock registers, so its new value is valid in the same cycle as the response.

// File: rtl/fg_pkg.sv
package fg_pkg;
   typedef enum logic [3:0] {
      K_CODE_RD  = 4'd0,
      K_SRAM_RD  = 4'd1,
      K_VERIFY   = 4'd2,
      K_FETCH    = 4'd3,
      K_PROG_LCK = 4'd4,
      K_PROG_KEY = 4'd5,
      K_PROG_OPT = 4'd6,
      K_ERASE    = 4'd7,
      K_INFO_RD  = 4'd8
   } req_kind_e;

   localparam logic [7:0] BLOCKED_BYTE = 8'hFF;
   localparam logic [7:0] ERASED_BYTE  = 8'hFF;
endpackage

// File: rtl/fg_lock_store.sv
module fg_lock_store (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       prog_en,
   input  logic [2:0] prog_bits,
   input  logic       erase,
   output logic [2:0] lock_o,
   output logic [1:0] level_o
);
   logic [2:0] lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lock_q <= 3'b111;
      else if (erase)   lock_q <= 3'b111;
      else if (prog_en) lock_q <= lock_q & prog_bits;
   end

   always_comb begin
      if (!lock_q[2])      level_o = 2'd3;
      else if (!lock_q[1]) level_o = 2'd2;
      else if (!lock_q[0]) level_o = 2'd1;
      else                 level_o = 2'd0;
   end

   assign lock_o = lock_q;
endmodule

// File: rtl/fg_key_store.sv
module fg_key_store #(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_idx,
   input  logic [7:0]    wr_byte,
   input  logic          erase,
   input  logic [AW-1:0] rd_idx,
   output logic [7:0]    rd_byte,
   output logic          scramble_on
);
   logic [7:0]       key_q [DEPTH];
   logic [DEPTH-1:0] touched;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || erase) begin
         for (int i = 0; i < DEPTH; i++) key_q[i] <= fg_pkg::ERASED_BYTE;
      end else if (wr_en) begin
         key_q[wr_idx] <= wr_byte;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_mark
      assign touched[g] = (key_q[g] != fg_pkg::ERASED_BYTE);
   end

   assign scramble_on = |touched;
   assign rd_byte     = key_q[rd_idx];
endmodule

// File: rtl/fg_info_rom.sv
module fg_info_rom #(
   parameter int         ADDR_W = 16,
   parameter logic [7:0] DEV_ID = 8'h43
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wdog_off,
   output logic [7:0]        data
);
   always_comb begin
      case (addr)
         ADDR_W'('h30): data = 8'hDA;
         ADDR_W'('h31): data = DEV_ID;
         ADDR_W'('h60): data = 8'h01;
         ADDR_W'('hFC): data = {4'hF, wdog_off, 3'b111};
         default:       data = 8'hFF;
      endcase
   end
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
   parameter int         ADDR_W    = 16,
   parameter int         KEY_DEPTH = 64,
   parameter logic [7:0] DEV_ID    = 8'h43,
   localparam int        KEY_AW    = $clog2(KEY_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_rst_i,
   input  logic              ea_pin_i,
   input  logic              req_valid_i,
   input  logic [3:0]        req_kind_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [7:0]        req_wdata_i,
   input  logic [7:0]        mem_rdata_i,
   output logic              rsp_valid_o,
   output logic [7:0]        rsp_data_o,
   output logic              viol_o,
   output logic              rsp_err_o,
   output logic              prog_erase_o,
   output logic [1:0]        lvl_o,
   output logic              ea_o
);
   import fg_pkg::*;

   if (KEY_DEPTH < 2 || (KEY_DEPTH & (KEY_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("KEY_DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < 8 || KEY_AW > ADDR_W) begin : g_bad_addr
      $error("ADDR_W must hold the info addresses and the key index");
   end

   logic [2:0]  lock_bits;
   logic [1:0]  level;
   logic [7:0]  key_byte, info_byte;
   logic        scramble_on;
   logic        wdog_off_q, ea_hold_q;
   logic        wr_lock, wr_key, wr_opt, do_erase, refuse, err_n;
   logic [7:0]  data_n;

   fg_lock_store i_lock (
      .clk(clk), .rst_n(rst_n), .prog_en(wr_lock), .prog_bits(req_wdata_i[2:0]),
      .erase(do_erase), .lock_o(lock_bits), .level_o(level)
   );

   fg_key_store #(.DEPTH(KEY_DEPTH)) i_key (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_key), .wr_idx(req_addr_i[KEY_AW-1:0]),
      .wr_byte(req_wdata_i), .erase(do_erase), .rd_idx(req_addr_i[KEY_AW-1:0]),
      .rd_byte(key_byte), .scramble_on(scramble_on)
   );

   fg_info_rom #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) i_info (
      .addr(req_addr_i), .wdog_off(wdog_off_q), .data(info_byte)
   );

   always_comb begin
      wr_lock  = 1'b0;
      wr_key   = 1'b0;
      wr_opt   = 1'b0;
      do_erase = 1'b0;
      refuse   = 1'b0;
      err_n    = 1'b0;
      data_n   = 8'h00;
      if (req_valid_i) begin
         case (req_kind_e'(req_kind_i))
            K_CODE_RD: begin refuse = (level >= 2'd1); data_n = mem_rdata_i; end
            K_SRAM_RD: begin refuse = (level >= 2'd2); data_n = mem_rdata_i; end
            K_VERIFY: begin
               refuse = (level >= 2'd2);
               data_n = scramble_on ? ~(mem_rdata_i ^ key_byte) : mem_rdata_i;
            end
            K_FETCH:    begin refuse = (level == 2'd3); data_n = mem_rdata_i; end
            K_PROG_LCK: wr_lock = 1'b1;
            K_PROG_KEY: begin err_n = (level != 2'd0); wr_key = (level == 2'd0); end
            K_PROG_OPT: begin err_n = (level != 2'd0); wr_opt = (level == 2'd0); end
            K_ERASE:    do_erase = 1'b1;
            K_INFO_RD:  data_n = info_byte;
            default:    err_n = 1'b1;
         endcase
         if (refuse) data_n = BLOCKED_BYTE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o  <= 1'b0;
         rsp_data_o   <= 8'h00;
         viol_o       <= 1'b0;
         rsp_err_o    <= 1'b0;
         prog_erase_o <= 1'b0;
         wdog_off_q   <= 1'b1;
         ea_hold_q    <= 1'b0;
      end else begin
         rsp_valid_o  <= req_valid_i;
         rsp_data_o   <= data_n;
         viol_o       <= refuse;
         rsp_err_o    <= err_n;
         prog_erase_o <= do_erase;
         if (wr_opt)    wdog_off_q <= req_wdata_i[3];
         if (cpu_rst_i) ea_hold_q  <= ea_pin_i;
      end
   end

   assign lvl_o = level;
   assign ea_o  = (level == 2'd0) ? ea_pin_i : ea_hold_q;
endmodule

// File: rtl/fg_checker.sv
module fg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [3:0] req_kind,
   input logic [2:0] lock,
   input logic [1:0] lvl,
   input logic       rsp_valid,
   input logic [7:0] rsp_data,
   input logic       viol,
   input logic       err,
   input logic       prog_erase
);
   p_lock_tighten_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_kind == 4'd7) |=> ((lock & ~$past(lock)) == 3'b000));

   p_erase_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 4'd7) |=> (prog_erase && lock == 3'b111));

   p_verify_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 4'd2 && lvl >= 2'd2) |=> (viol && rsp_data == 8'hFF));

   p_fetch_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 4'd3 && lvl == 2'd3) |=> viol);

   p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !viol && !err && !prog_erase));

   p_viol_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> (rsp_data == 8'hFF && !err));
endmodule

bind flash_guard fg_checker i_fg_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid_i), .req_kind(req_kind_i),
   .lock(lock_bits), .lvl(lvl_o), .rsp_valid(rsp_valid_o), .rsp_data(rsp_data_o),
   .viol(viol_o), .err(rsp_err_o), .prog_erase(prog_erase_o)
);

// File: tb/test_flash_guard.sv
module test_flash_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_rst = 1'b0;
   logic        ea_pin = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_kind = 4'd0;
   logic [15:0] req_addr = 16'd0;
   logic [7:0]  req_wdata = 8'd0;
   logic [7:0]  mem_rdata = 8'd0;
   logic        rsp_valid, viol, rsp_err, prog_erase, ea_o;
   logic [7:0]  rsp_data;
   logic [1:0]  lvl;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   flash_guard i_flash_guard (
      .clk(clk), .rst_n(rst_n), .cpu_rst_i(cpu_rst), .ea_pin_i(ea_pin),
      .req_valid_i(req_valid), .req_kind_i(req_kind), .req_addr_i(req_addr),
      .req_wdata_i(req_wdata), .mem_rdata_i(mem_rdata), .rsp_valid_o(rsp_valid),
      .rsp_data_o(rsp_data), .viol_o(viol), .rsp_err_o(rsp_err),
      .prog_erase_o(prog_erase), .lvl_o(lvl), .ea_o(ea_o)
   );

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Drive at falling edge, results are due just after the next rising edge.
   task automatic issue(input logic [3:0] k, input logic [15:0] a,
                        input logic [7:0] wd, input logic [7:0] md);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; mem_rdata = md;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic t_reset;
      check("R12 idle rsp_valid", 16'(rsp_valid), 16'd0);
      check("R1 reset level", 16'(lvl), 16'd0);
      ea_pin = 1'b1; #1;
      check("R11 ea follows at level 0", 16'(ea_o), 16'd1);
   endtask

   task automatic t_info;
      issue(4'd8, 16'h0030, 8'h00, 8'h00);
      check("R12 rsp_valid", 16'(rsp_valid), 16'd1);
      check("R10 sig 30h", 16'(rsp_data), 16'h00DA);
      issue(4'd8, 16'h0031, 8'h00, 8'h00);
      check("R10 sig 31h", 16'(rsp_data), 16'h0043);
      issue(4'd8, 16'h0060, 8'h00, 8'h00);
      check("R10 sig 60h", 16'(rsp_data), 16'h0001);
      issue(4'd8, 16'h0061, 8'h00, 8'h00);
      check("R10 other addr", 16'(rsp_data), 16'h00FF);
      issue(4'd8, 16'h00FC, 8'h00, 8'h00);
      check("R9 option reset", 16'(rsp_data), 16'h00FF);
      issue(4'd6, 16'h0000, 8'hF7, 8'h00);
      check("R8 option prog ok", 16'(rsp_err), 16'd0);
      issue(4'd8, 16'h00FC, 8'h00, 8'h00);
      check("R9 option flag 0", 16'(rsp_data), 16'h00F7);
      @(posedge clk); #1;
      check("R12 one-cycle response", 16'(rsp_valid), 16'd0);
   endtask

   task automatic t_verify_plain_and_key;
      issue(4'd2, 16'h0005, 8'h00, 8'h5A);
      check("R6 erased key plain", 16'(rsp_data), 16'h005A);
      issue(4'd5, 16'h0005, 8'h0F, 8'h00);
      check("R8 key prog ok at level 0", 16'(rsp_err), 16'd0);
      issue(4'd2, 16'h0045, 8'h00, 8'h5A);
      check("R6 scrambled index 5", 16'(rsp_data), 16'h00AA);
      issue(4'd2, 16'h0006, 8'h00, 8'h5A);
      check("R6 scrambled with FF byte", 16'(rsp_data), 16'h005A);
      issue(4'd0, 16'h1234, 8'h00, 8'h3C);
      check("R4 code read at level 0", 16'(rsp_data), 16'h003C);
      check("R4 no viol at level 0", 16'(viol), 16'd0);
   endtask

   task automatic t_level2;
      issue(4'd4, 16'h0000, 8'h06, 8'h00);
      check("R1 LB1 cleared gives 1", 16'(lvl), 16'd1);
      issue(4'd0, 16'h0100, 8'h00, 8'h3C);
      check("R4 code read refused data", 16'(rsp_data), 16'h00FF);
      check("R4 code read viol", 16'(viol), 16'd1);
      issue(4'd1, 16'h0010, 8'h00, 8'h77);
      check("R5 SRAM read ok at 1", 16'(rsp_data), 16'h0077);
      issue(4'd5, 16'h0005, 8'h00, 8'h00);
      check("R8 key prog refused", 16'(rsp_err), 16'd1);
      issue(4'd2, 16'h0005, 8'h00, 8'h5A);
      check("R8 key byte unchanged", 16'(rsp_data), 16'h00AA);
      issue(4'd6, 16'h0000, 8'hFF, 8'h00);
      check("R8 option prog refused", 16'(rsp_err), 16'd1);
      issue(4'd8, 16'h00FC, 8'h00, 8'h00);
      check("R8 option unchanged", 16'(rsp_data), 16'h00F7);
      issue(4'd4, 16'h0000, 8'h07, 8'h00);
      check("R2 cannot loosen", 16'(lvl), 16'd1);
   endtask

   task automatic t_ea_latch;
      @(negedge clk); ea_pin = 1'b1; cpu_rst = 1'b1;
      @(negedge clk); cpu_rst = 1'b0; ea_pin = 1'b0;
      @(negedge clk);
      check("R11 ea held", 16'(ea_o), 16'd1);
   endtask

   task automatic t_level3_4;
      issue(4'd4, 16'h0000, 8'h05, 8'h00);
      check("R1 LB2 cleared gives 2", 16'(lvl), 16'd2);
      issue(4'd2, 16'h0005, 8'h00, 8'h5A);
      check("R6 verify refused", 16'(viol), 16'd1);
      issue(4'd1, 16'h0010, 8'h00, 8'h77);
      check("R5 SRAM read refused", 16'(rsp_data), 16'h00FF);
      issue(4'd3, 16'h2000, 8'h00, 8'h12);
      check("R7 fetch ok at 2", 16'(rsp_data), 16'h0012);
      issue(4'd4, 16'h0000, 8'h03, 8'h00);
      check("R1 LB3 cleared gives 3", 16'(lvl), 16'd3);
      issue(4'd3, 16'h2000, 8'h00, 8'h12);
      check("R7 fetch refused", 16'(viol), 16'd1);
      issue(4'd8, 16'h0031, 8'h00, 8'h00);
      check("R10 sig at level 3", 16'(rsp_data), 16'h0043);
   endtask

   task automatic t_erase;
      issue(4'd7, 16'h0000, 8'h00, 8'h00);
      check("R3 erase pulse", 16'(prog_erase), 16'd1);
      check("R3 level back to 0", 16'(lvl), 16'd0);
      issue(4'd2, 16'h0005, 8'h00, 8'h5A);
      check("R3 key erased verify plain", 16'(rsp_data), 16'h005A);
      check("R3 pulse one cycle", 16'(prog_erase), 16'd0);
      issue(4'd8, 16'h00FC, 8'h00, 8'h00);
      check("R3 option kept", 16'(rsp_data), 16'h00F7);
      issue(4'd4, 16'h0000, 8'h03, 8'h00);
      check("R1 LB3 alone gives 3", 16'(lvl), 16'd3);
      issue(4'd7, 16'h0000, 8'h00, 8'h00);
      issue(4'd4, 16'h0000, 8'h05, 8'h00);
      check("R1 LB2 alone gives 2", 16'(lvl), 16'd2);
      issue(4'd15, 16'h0000, 8'h00, 8'h00);
      check("R12 unknown kind error", 16'(rsp_err), 16'd1);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_info();
      t_verify_plain_and_key();
      t_level2();
      t_ea_latch();
      t_level3_4();
      t_erase();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule